// File: doc/BRIEF.md
# Trace Data Monitor Capture Unit

This block watches a parallel monitor bus made of 8-bit lanes and samples it on every rising clock edge. Each lane is kept only when the global run bit and that lane's enable bit are both set. Lanes that are not kept read as zero before any later stage sees them. From the gated sample the unit may emit a data set element. It can emit on every sample (streaming mode) or only when the sample differs from the last element it emitted (change mode). Two independent masked pattern comparators look at the same gated sample. One produces a trigger pulse. The other produces a timestamp-request pulse, and only while timestamp requests are enabled.

Software sets the unit up through a simple write/read register port. Register map (the address is `regAddr`):

- Address 0, control: bit 0 is run, bit 1 is change mode, bit 2 is timestamp enable.
- Address 1: the lane enables.
- Address 2: the trigger pattern.
- Address 3: the trigger mask.
- Address 4: the timestamp pattern.
- Address 5: the timestamp mask.
- Any other address reads as zero.

A mask bit of 1 compares the pattern bit with the same index. A mask bit of 0 ignores that bit. All outputs are registered one cycle after the sample they describe.

Top module: `trace_capture_unit`

## Requirements
- R1: After reset, `elemValid`, `trigPulse` and `tsReq` are 0, and every register reads back as 0.
- R2: With run=1 and change mode=0, every sample produces `elemValid`=1 one cycle later, with `elemData` equal to the gated sample.
- R3: With run=1 and change mode=1, an element is emitted only when the gated sample differs from the previous emitted element. The first sample after run rises always emits.
- R4: While run=0 no element, trigger or timestamp request is produced, and the previous-element reference is cleared.
- R5: Byte lane n (bits 8n+7..8n) of the gated sample is zero unless run=1 and lane-enable bit n is 1. Gating happens before change detection and before pattern matching.
- R6: Lane-enable bits at or above the implemented lane count (4 by default) read back as 0 and ignore writes.
- R7: `trigPulse` is 1 for one cycle after each sample taken while run=1 whose gated value equals the trigger pattern on every bit where the trigger mask is 1. This holds regardless of whether an element is emitted.
- R8: `tsReq` is 1 for one cycle after a sample that matches the timestamp pattern under the timestamp mask, and only when control bit 2 was set for that sample.
- R9: An all-zero mask matches every sample taken while run=1.
- R10: The control bits [2:0], the lane enables and the four pattern and mask words read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rstN | input | 1 | Active-low reset, synchronous |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data, combinational from `regAddr` |
| monData | input | NUM_LANES*LANE_W | Monitor bus sample |
| elemValid | output | 1 | Element emitted this cycle |
| elemData | output | NUM_LANES*LANE_W | Emitted element value |
| trigPulse | output | 1 | Trigger pattern match pulse |
| tsReq | output | 1 | Timestamp request pulse |

## Verification
The assertions assume the control register stays put while a sample is in flight. Change-mode and lane-zero properties compare an output with the control state one cycle earlier, so a configuration write lands between samples and never inside one. The stimulus writes only through the register port on a falling edge and changes the monitor bus on the same edge. A bench-side model applies each write after the sample of the same cycle, matching the one-cycle latency the properties rely on.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef struct packed {
    logic run;
    logic onChange;
    logic tsOn;
  } tcuStrobes_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_LANES = 1;
  localparam int unsigned ADDR_TRIG_PAT = 2;
  localparam int unsigned ADDR_TRIG_MASK = 3;
  localparam int unsigned ADDR_TS_PAT = 4;
  localparam int unsigned ADDR_TS_MASK = 5;
endpackage

// File: rtl/tcu_regs.sv
module tcu_regs
  import tcu_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W = 8,
  parameter int REG_W = 32,
  parameter int ADDR_W = 3,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output tcuStrobes_t       strobes,
  output logic [NUM_LANES-1:0] laneEn,
  output logic [DATA_W-1:0] trigPat,
  output logic [DATA_W-1:0] trigMask,
  output logic [DATA_W-1:0] tsPat,
  output logic [DATA_W-1:0] tsMask
);
  logic [2:0] ctrlQ;
  logic [NUM_LANES-1:0] laneQ;
  logic [DATA_W-1:0] trigPatQ, trigMaskQ, tsPatQ, tsMaskQ;

  // Only the implemented lane bits are stored; higher bits are dropped.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      laneQ <= '0;
      trigPatQ <= '0;
      trigMaskQ <= '0;
      tsPatQ <= '0;
      tsMaskQ <= '0;
    end else if (regWe) begin
      case (int'(regAddr))
        ADDR_CTRL:      ctrlQ <= regWdata[2:0];
        ADDR_LANES:     laneQ <= regWdata[NUM_LANES-1:0];
        ADDR_TRIG_PAT:  trigPatQ <= regWdata[DATA_W-1:0];
        ADDR_TRIG_MASK: trigMaskQ <= regWdata[DATA_W-1:0];
        ADDR_TS_PAT:    tsPatQ <= regWdata[DATA_W-1:0];
        ADDR_TS_MASK:   tsMaskQ <= regWdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (DATA_W < REG_W) begin : g_padBits
      logic unusedWdataHigh;
      assign unusedWdataHigh = ^regWdata[REG_W-1:DATA_W];
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    case (int'(regAddr))
      ADDR_CTRL:      regRdata = REG_W'(ctrlQ);
      ADDR_LANES:     regRdata = REG_W'(laneQ);
      ADDR_TRIG_PAT:  regRdata = REG_W'(trigPatQ);
      ADDR_TRIG_MASK: regRdata = REG_W'(trigMaskQ);
      ADDR_TS_PAT:    regRdata = REG_W'(tsPatQ);
      ADDR_TS_MASK:   regRdata = REG_W'(tsMaskQ);
      default:        regRdata = '0;
    endcase
  end

  assign strobes.run = ctrlQ[0];
  assign strobes.onChange = ctrlQ[1];
  assign strobes.tsOn = ctrlQ[2];
  assign laneEn = laneQ;
  assign trigPat = trigPatQ;
  assign trigMask = trigMaskQ;
  assign tsPat = tsPatQ;
  assign tsMask = tsMaskQ;
endmodule

// File: rtl/tcu_lane_gate.sv
module tcu_lane_gate #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic                 run,
  input  logic [NUM_LANES-1:0] laneEn,
  input  logic [DATA_W-1:0]    rawData,
  output logic [DATA_W-1:0]    gatedData
);
  generate
    for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
      assign gatedData[lane*LANE_W +: LANE_W] =
        (run && laneEn[lane]) ? rawData[lane*LANE_W +: LANE_W] : '0;
    end
  endgenerate
endmodule

// File: rtl/tcu_match.sv
module tcu_match #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] careMask,
  output logic              hit
);
  // A mask bit of 1 compares the pattern bit with the same index.
  assign hit = ~|((sample ^ pattern) & careMask);
endmodule

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tcuStrobes_t          strobes,
  input  logic [NUM_LANES-1:0] laneEn,
  input  logic [DATA_W-1:0]    monData,
  input  logic [DATA_W-1:0]    trigPat,
  input  logic [DATA_W-1:0]    trigMask,
  input  logic [DATA_W-1:0]    tsPat,
  input  logic [DATA_W-1:0]    tsMask,
  output logic                 elemValid,
  output logic [DATA_W-1:0]    elemData,
  output logic                 trigPulse,
  output logic                 tsReq
);
  logic [DATA_W-1:0] gatedData;
  logic [DATA_W-1:0] prevQ;
  logic primedQ;
  logic trigHit, tsHit, emitNow;

  tcu_lane_gate #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) gate_i (
    .run(strobes.run),
    .laneEn(laneEn),
    .rawData(monData),
    .gatedData(gatedData)
  );

  tcu_match #(.DATA_W(DATA_W)) trigMatch_i (
    .sample(gatedData), .pattern(trigPat), .careMask(trigMask), .hit(trigHit)
  );

  tcu_match #(.DATA_W(DATA_W)) tsMatch_i (
    .sample(gatedData), .pattern(tsPat), .careMask(tsMask), .hit(tsHit)
  );

  // Emit always in streaming mode; in change mode on first sample or on a difference.
  assign emitNow = !strobes.onChange || !primedQ || (gatedData != prevQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elemValid <= 1'b0;
      elemData <= '0;
      trigPulse <= 1'b0;
      tsReq <= 1'b0;
      prevQ <= '0;
      primedQ <= 1'b0;
    end else if (!strobes.run) begin
      elemValid <= 1'b0;
      trigPulse <= 1'b0;
      tsReq <= 1'b0;
      prevQ <= '0;
      primedQ <= 1'b0;
    end else begin
      elemValid <= emitNow;
      trigPulse <= trigHit;
      tsReq <= strobes.tsOn && tsHit;
      if (emitNow) begin
        elemData <= gatedData;
        prevQ <= gatedData;
        primedQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_capture_unit.sv
module trace_capture_unit
  import tcu_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W = 8,
  parameter int REG_W = 32,
  parameter int ADDR_W = 3,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [DATA_W-1:0] monData,
  output logic              elemValid,
  output logic [DATA_W-1:0] elemData,
  output logic              trigPulse,
  output logic              tsReq
);
  tcuStrobes_t ctlStrobes;
  logic [NUM_LANES-1:0] laneEn;
  logic [DATA_W-1:0] trigPat, trigMask, tsPat, tsMask;

  tcu_regs #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobes(ctlStrobes),
    .laneEn(laneEn), .trigPat(trigPat), .trigMask(trigMask),
    .tsPat(tsPat), .tsMask(tsMask)
  );

  tcu_datapath #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(ctlStrobes), .laneEn(laneEn),
    .monData(monData), .trigPat(trigPat), .trigMask(trigMask),
    .tsPat(tsPat), .tsMask(tsMask), .elemValid(elemValid),
    .elemData(elemData), .trigPulse(trigPulse), .tsReq(tsReq)
  );
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 run,
  input logic                 onChange,
  input logic                 tsOn,
  input logic [NUM_LANES-1:0] laneEn,
  input logic                 elemValid,
  input logic [DATA_W-1:0]    elemData,
  input logic                 trigPulse,
  input logic                 tsReq
);
  // R2: streaming mode emits an element for every sample.
  assert_stream_every_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    (run && !onChange) |=> elemValid);

  // R3: back-to-back change-mode elements never repeat a value.
  assert_change_differs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && $past(elemValid) && $past(onChange)) |-> (elemData != $past(elemData)));

  // R4: nothing leaves the unit for a sample taken while stopped.
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!elemValid && !trigPulse && !tsReq));

  // R8: a timestamp request needs the enable bit for its sample.
  assert_ts_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    tsReq |-> ($past(tsOn) && $past(run)));

  generate
    for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_laneChk
      // R5: an element carries zeros in every lane that was disabled.
      assert_lane_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
        elemValid |-> ($past(laneEn[lane]) || (elemData[lane*LANE_W +: LANE_W] == '0)));
    end
  endgenerate
endmodule

bind trace_capture_unit tcu_checker #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rstN(rstN), .run(ctlStrobes.run), .onChange(ctlStrobes.onChange),
  .tsOn(ctlStrobes.tsOn), .laneEn(laneEn), .elemValid(elemValid),
  .elemData(elemData), .trigPulse(trigPulse), .tsReq(tsReq)
);

// File: tb/trace_capture_unit_tb.sv
module trace_capture_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] monData = '0;
  logic elemValid, trigPulse, tsReq;
  logic [31:0] elemData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of configuration and change state
  logic mEn = 0, mMode = 0, mTs = 0;
  logic [3:0] mLanes = '0;
  logic [31:0] mTp = '0, mTm = '0, mSp = '0, mSm = '0;
  logic [31:0] mPrev = '0;
  logic mFirst = 1;
  logic [31:0] lastData = '0;

  trace_capture_unit dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .monData(monData), .elemValid(elemValid), .elemData(elemData),
    .trigPulse(trigPulse), .tsReq(tsReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at falling edge, check registered outputs just after rising edge.
  task automatic cycle(input logic we, input logic [2:0] addr, input logic [31:0] wd,
                       input logic [31:0] d, input string tagOverride);
    logic [31:0] g;
    logic expV, expT, expS;
    string tagE;
    @(negedge clk);
    regWe = we; regAddr = addr; regWdata = wd; monData = d; lastData = d;
    g = '0;
    for (int l = 0; l < 4; l++)
      if (mEn && mLanes[l]) g[l*8 +: 8] = d[l*8 +: 8];
    expV = mEn && (!mMode || mFirst || g != mPrev);
    expT = mEn && (((g ^ mTp) & mTm) == 0);
    expS = mEn && mTs && (((g ^ mSp) & mSm) == 0);
    tagE = !mEn ? "R4" : (mMode ? "R3" : "R2");
    if (tagOverride != "") tagE = tagOverride;
    if (!mEn) begin mPrev = '0; mFirst = 1; end
    else if (expV) begin mPrev = g; mFirst = 0; end
    if (we) begin
      case (addr)
        3'd0: begin mEn = wd[0]; mMode = wd[1]; mTs = wd[2]; end
        3'd1: mLanes = wd[3:0];
        3'd2: mTp = wd;
        3'd3: mTm = wd;
        3'd4: mSp = wd;
        3'd5: mSm = wd;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk({tagE, " elemValid"}, 32'(elemValid), 32'(expV));
    if (expV) chk({tagE, " elemData"}, elemData, g);
    chk((mTm == 0 && mEn) ? "R9 trigPulse" : "R7 trigPulse", 32'(trigPulse), 32'(expT));
    chk((mSm == 0 && mEn && mTs) ? "R9 tsReq" : "R8 tsReq", 32'(tsReq), 32'(expS));
    regWe = 0;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [31:0] wd);
    cycle(1'b1, addr, wd, lastData, "");
  endtask

  task automatic rd(input logic [2:0] addr, input logic [31:0] exp, input string tag);
    cycle(1'b0, addr, 32'h0, lastData, "");
    chk({tag, " readback"}, regRdata, exp);
  endtask

  task automatic smp(input logic [31:0] d);
    cycle(1'b0, 3'd7, 32'h0, d, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    chk("R1 elemValid", 32'(elemValid), 0);
    chk("R1 trigPulse", 32'(trigPulse), 0);
    chk("R1 tsReq", 32'(tsReq), 0);
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1");

    // R10 readback and R6 unimplemented lane bits
    wr(3'd2, 32'hDEAD_BEEF); rd(3'd2, 32'hDEAD_BEEF, "R10");
    wr(3'd3, 32'h1234_5678); rd(3'd3, 32'h1234_5678, "R10");
    wr(3'd4, 32'hCAFE_F00D); rd(3'd4, 32'hCAFE_F00D, "R10");
    wr(3'd5, 32'h0F0F_0F0F); rd(3'd5, 32'h0F0F_0F0F, "R10");
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, 32'h0000_000F, "R6");
    wr(3'd1, 32'h0000_00F0); rd(3'd1, 32'h0, "R6");
    wr(3'd0, 32'hFFFF_FFF8); rd(3'd0, 32'h0, "R10");

    // R2/R5: streaming mode across all lane-enable combinations, trigger mask zero (R9)
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h1);
    for (int m = 0; m < 16; m++) begin
      wr(3'd1, 32'(m));
      cycle(1'b0, 3'd7, 32'h0, 32'hA5C3_7E19, "R5");
      cycle(1'b0, 3'd7, 32'h0, 32'h5A3C_81E6, "R5");
      cycle(1'b0, 3'd7, 32'h0, 32'h5A3C_81E6, "R2");
    end

    // R3: change mode with repeats; differences only in a disabled lane are ignored (R5)
    wr(3'd1, 32'hF);
    wr(3'd0, 32'h3);
    smp(32'h1111_1111); smp(32'h1111_1111); smp(32'h1111_1111);
    smp(32'h2222_2222); smp(32'h2222_2222); smp(32'h1111_1111);
    wr(3'd1, 32'h7);
    smp(32'h0011_1111); smp(32'hFF11_1111); smp(32'h0011_1111);
    smp(32'h0011_1112);

    // R4: stop, then restart with the same value: first sample emits again
    wr(3'd0, 32'h2);
    smp(32'h0011_1112); smp(32'h0011_1112);
    wr(3'd0, 32'h3);
    smp(32'h0011_1112); smp(32'h0011_1112); smp(32'h0011_1112);

    // R7: full-mask trigger, single-bit sweep with and without masking that bit
    wr(3'd1, 32'hF);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h9ABC_DEF0);
    wr(3'd3, 32'hFFFF_FFFF);
    smp(32'h9ABC_DEF0);
    for (int b = 0; b < 32; b++) begin
      smp(32'h9ABC_DEF0 ^ (32'h1 << b));
      wr(3'd3, ~(32'h1 << b));
      smp(32'h9ABC_DEF0 ^ (32'h1 << b));
      wr(3'd3, 32'hFFFF_FFFF);
    end

    // R8: timestamp match blocked until enable bit set, mask zero matches everything (R9)
    wr(3'd4, 32'h0000_00AA);
    wr(3'd5, 32'h0000_00FF);
    smp(32'h1234_56AA); smp(32'h1234_56AB);
    wr(3'd0, 32'h5);
    smp(32'h1234_56AA); smp(32'h1234_56AB); smp(32'h7777_77AA);
    wr(3'd5, 32'h0);
    smp(32'h0000_0001); smp(32'hFFFF_FFFF);
    wr(3'd0, 32'h4);
    smp(32'h0000_00AA); smp(32'h0000_00AA);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule